// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block turns byte-pair write requests into the slow, step-timed waveform that a physical-layer macro expects on its test/configuration port. Each request carries an 8-bit register selector (the code) and an 8-bit value (the data). Both travel over one shared 8-bit bus. The PHY latches the code on a falling edge of the test clock while the enable line is high. It commits the data on the following rising edge while the enable line is low.

A write runs as six phases of equal length: code placed, enable raised, clock dropped, enable dropped, data placed, clock raised. The test clock sits high between writes. The phase length comes from a divider input, counted in system-clock cycles.

A second request type runs the clear sequence. The clear line is held high for a programmable number of cycles and then released. A settling wait of the same length follows before the block accepts the next request. The clock stays high throughout. Each request type has its own valid/ready pair. A clear wins over a write offered in the same cycle, and nothing is accepted while a sequence is running.

Top module: `phy_tport_seq`

## Requirements
- R1: After a synchronous reset: `tp_clk` is 1, `tp_en` is 0, `tp_clr` is 0, `tp_din` is 0x00, and both `wr_ready` and `clr_ready` are 1.
- R2: A write is taken on a rising edge where `wr_valid` and `wr_ready` are both 1. Let N be `step_div`, with 0 counted as 1. `wr_ready` then stays 0 for exactly 6*N cycles and returns to 1 on the 6*N-th edge after acceptance.
- R3: Counting edges from the acceptance edge k:
  - `tp_din` shows the code from edge k.
  - `tp_en` rises at k+N.
  - `tp_clk` falls at k+2N.
  - `tp_en` falls at k+3N.
  - `tp_din` shows the data from k+4N.
  - `tp_clk` rises at k+5N.
- R4: `tp_en` is 1 and `tp_din` is unchanged (the code) on the cycle `tp_clk` falls. `tp_en` is 0 and `tp_din` is unchanged (the data) on the cycle `tp_clk` rises.
- R5: While no sequence runs: `tp_clk` is 1, `tp_en` and `tp_clr` are 0, and `tp_din` keeps the last byte driven (the data of the last write, 0x00 after reset).
- R6: A clear is taken on an edge where `clr_valid` and `clr_ready` are both 1. Let H be `clr_hold`, with 0 counted as 1. `tp_clr` is 1 for H cycles, then 0 for H more cycles. `tp_clk` stays 1 and both readies stay 0 for these 2*H cycles.
- R7: When idle and `clr_valid` is 1, `wr_ready` is 0 and `clr_ready` is 1. A write offered in the same cycle is not started, and only the clear waveform appears.
- R8: Any `wr_valid`, `clr_valid` or `wr_code` activity during a running sequence is ignored. The waveform is unchanged and both readies stay 0.
- R9: `step_div` = 0 behaves as 1, and `clr_hold` = 0 behaves as 1.
- R10: The phase length is taken at acceptance. Changing `step_div` while a write runs does not alter that write's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_div | input | DIV_W | Cycles per write phase (0 treated as 1) |
| clr_hold | input | HOLD_W | Cycles for each half of the clear sequence (0 treated as 1) |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken this cycle |
| wr_code | input | 8 | Register selector byte of the write |
| wr_data | input | 8 | Value byte of the write |
| clr_valid | input | 1 | Clear request present |
| clr_ready | output | 1 | Clear request can be taken this cycle |
| tp_clk | output | 1 | Test-port clock to the PHY |
| tp_en | output | 1 | Test-port enable (high marks the code phase) |
| tp_din | output | 8 | Test-port shared code/data bus |
| tp_clr | output | 1 | Test-port clear |

## Verification
The assertions assume the following about the inputs:
- The request and configuration inputs are known (not X) once reset is released.
- `step_div` and `clr_hold` matter only on the acceptance edge.
- A requester keeps its valid high until it sees ready.

The stimulus holds each request steady from one falling clock edge to the acceptance edge, then drops it. Extra requests and divider changes are injected only inside the busy window. Every such injection is withdrawn well before the running sequence ends, so no stray request is taken at the next idle edge.

// File: rtl/tport_pkg.sv
`timescale 1ns/1ps
package tport_pkg;

    localparam int TP_W = 8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CODE,
        PH_EN_UP,
        PH_CLK_DN,
        PH_EN_DN,
        PH_DATA,
        PH_CLK_UP,
        PH_CLR_ON,
        PH_CLR_WAIT
    } phase_e;

    typedef struct packed {
        logic            clk;
        logic            en;
        logic            clr;
        logic [TP_W-1:0] din;
    } port_t;

    localparam port_t PORT_RESET = '{clk: 1'b1, en: 1'b0, clr: 1'b0, din: '0};

    // Successor of a running phase once its timer has expired.
    function automatic phase_e phase_after(phase_e ph);
        phase_e n;
        case (ph)
            PH_CODE:     n = PH_EN_UP;
            PH_EN_UP:    n = PH_CLK_DN;
            PH_CLK_DN:   n = PH_EN_DN;
            PH_EN_DN:    n = PH_DATA;
            PH_DATA:     n = PH_CLK_UP;
            PH_CLR_ON:   n = PH_CLR_WAIT;
            default:     n = PH_IDLE;
        endcase
        return n;
    endfunction

    // Pin levels that belong to a phase.
    function automatic port_t drive_for(phase_e ph, logic [TP_W-1:0] code,
                                        logic [TP_W-1:0] data, logic [TP_W-1:0] hold);
        port_t o;
        o.clk = 1'b1;
        o.en  = 1'b0;
        o.clr = 1'b0;
        o.din = hold;
        case (ph)
            PH_CODE:   o.din = code;
            PH_EN_UP:  begin o.din = code; o.en = 1'b1; end
            PH_CLK_DN: begin o.din = code; o.en = 1'b1; o.clk = 1'b0; end
            PH_EN_DN:  begin o.din = code; o.clk = 1'b0; end
            PH_DATA:   begin o.din = data; o.clk = 1'b0; end
            PH_CLK_UP: o.din = data;
            PH_CLR_ON: o.clr = 1'b1;
            default:   ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/tport_step_timer.sv
`timescale 1ns/1ps
module tport_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // A length of 0 or 1 both give a one-cycle phase.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - CNT_W'(1);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

    AST_TICK_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));  // R2

endmodule

// File: rtl/tport_fsm.sv
`timescale 1ns/1ps
module tport_fsm
    import tport_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [TP_W-1:0]  wr_code,
    input  logic [TP_W-1:0]  wr_data,
    input  logic             clr_valid,
    input  logic [DIV_W-1:0] step_div,
    input  logic [HOLD_W-1:0] clr_hold,
    input  logic             expired,
    output phase_e           phase,
    output phase_e           nxt_phase,
    output logic [TP_W-1:0]  nxt_code,
    output logic [TP_W-1:0]  nxt_data,
    output logic             load,
    output logic [CNT_W-1:0] load_len,
    output logic             wr_ready,
    output logic             clr_ready
);
    logic [TP_W-1:0]   code_q, data_q;
    logic [DIV_W-1:0]  step_q;
    logic [HOLD_W-1:0] hold_q;
    logic              idle, clr_go, wr_go, in_clear;

    assign idle      = (phase == PH_IDLE);
    assign clr_ready = idle;
    assign wr_ready  = idle && !clr_valid;
    assign clr_go    = clr_valid && clr_ready;
    assign wr_go     = wr_valid && wr_ready;
    assign in_clear  = (phase == PH_CLR_ON) || (phase == PH_CLR_WAIT);

    always_comb begin
        nxt_phase = phase;
        if (idle) begin
            if (clr_go)
                nxt_phase = PH_CLR_ON;
            else if (wr_go)
                nxt_phase = PH_CODE;
        end else if (expired) begin
            nxt_phase = phase_after(phase);
        end
    end

    assign nxt_code = wr_go ? wr_code : code_q;
    assign nxt_data = wr_go ? wr_data : data_q;
    assign load     = (nxt_phase != PH_IDLE) && (idle || expired);

    always_comb begin
        if (idle)
            load_len = clr_go ? CNT_W'(clr_hold) : CNT_W'(step_div);
        else if (in_clear)
            load_len = CNT_W'(hold_q);
        else
            load_len = CNT_W'(step_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            code_q <= '0;
            data_q <= '0;
            step_q <= '0;
            hold_q <= '0;
        end else begin
            phase  <= nxt_phase;
            code_q <= nxt_code;
            data_q <= nxt_data;
            if (wr_go)
                step_q <= step_div;
            if (clr_go)
                hold_q <= clr_hold;
        end
    end

    AST_STEP_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(step_q));  // R10

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        !(clr_go && wr_go));  // R7

endmodule

// File: rtl/tport_drive.sv
`timescale 1ns/1ps
module tport_drive
    import tport_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  phase_e          nxt_phase,
    input  logic [TP_W-1:0] nxt_code,
    input  logic [TP_W-1:0] nxt_data,
    output port_t           pins
);
    // Registered pins: no decode glitch reaches the PHY.
    always_ff @(posedge clk) begin
        if (rst)
            pins <= PORT_RESET;
        else
            pins <= drive_for(nxt_phase, nxt_code, nxt_data, pins.din);
    end

    AST_CLR_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        pins.clr |-> pins.clk);  // R6

endmodule

// File: rtl/phy_tport_seq.sv
`timescale 1ns/1ps
module phy_tport_seq
    import tport_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  step_div,
    input  logic [HOLD_W-1:0] clr_hold,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_code,
    input  logic [7:0]        wr_data,
    input  logic              clr_valid,
    output logic              clr_ready,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [7:0]        tp_din,
    output logic              tp_clr
);
    localparam int CNT_W = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;

    phase_e           phase, nxt_phase;
    logic [TP_W-1:0]  nxt_code, nxt_data;
    logic             load, expired;
    logic [CNT_W-1:0] load_len;
    port_t            pins;

    tport_fsm #(.DIV_W(DIV_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_code   (wr_code),
        .wr_data   (wr_data),
        .clr_valid (clr_valid),
        .step_div  (step_div),
        .clr_hold  (clr_hold),
        .expired   (expired),
        .phase     (phase),
        .nxt_phase (nxt_phase),
        .nxt_code  (nxt_code),
        .nxt_data  (nxt_data),
        .load      (load),
        .load_len  (load_len),
        .wr_ready  (wr_ready),
        .clr_ready (clr_ready)
    );

    tport_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len     (load_len),
        .expired (expired)
    );

    tport_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .nxt_phase (nxt_phase),
        .nxt_code  (nxt_code),
        .nxt_data  (nxt_data),
        .pins      (pins)
    );

    assign tp_clk = pins.clk;
    assign tp_en  = pins.en;
    assign tp_clr = pins.clr;
    assign tp_din = pins.din;

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (tp_clk && !tp_en && !tp_clr));  // R5

    AST_FALL_WITH_EN: assert property (@(posedge clk) disable iff (rst)
        $fell(tp_clk) |-> (tp_en && $stable(tp_din)));  // R4

    AST_RISE_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tp_clk) |-> (!tp_en && $stable(tp_din)));  // R4

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (!wr_ready && !clr_ready));  // R8

    AST_CLR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && clr_ready) |-> !wr_ready);  // R7

endmodule

// File: tb/phy_tport_seq_bench.sv
`timescale 1ns/1ps
module phy_tport_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  step_div = 8'd1;
    logic [15:0] clr_hold = 16'd1;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_code = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        clr_valid = 1'b0;
    logic        wr_ready, clr_ready, tp_clk, tp_en, tp_clr;
    logic [7:0]  tp_din;

    always #5 clk = ~clk;

    phy_tport_seq u_phy_tport_seq (
        .clk(clk), .rst(rst), .step_div(step_div), .clr_hold(clr_hold),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_code(wr_code), .wr_data(wr_data),
        .clr_valid(clr_valid), .clr_ready(clr_ready),
        .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din), .tp_clr(tp_clr)
    );

    typedef struct {
        logic       rdy;
        logic       ck;
        logic       en;
        logic       cl;
        logic [7:0] din;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    int         checks = 0;
    int         fails = 0;
    logic [7:0] last_din = 8'h00;

    // Monitor: one expected snapshot per falling edge.
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if ({wr_ready, tp_clk, tp_en, tp_clr, tp_din} !== {e.rdy, e.ck, e.en, e.cl, e.din}) begin
                fails++;
                $display("FAIL %s: actual rdy=%b clk=%b en=%b clr=%b din=%h expected rdy=%b clk=%b en=%b clr=%b din=%h",
                         e.tag, wr_ready, tp_clk, tp_en, tp_clr, tp_din,
                         e.rdy, e.ck, e.en, e.cl, e.din);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic r, input logic c, input logic e, input logic l,
                        input logic [7:0] d, input string tag);
        exp_t x;
        x.rdy = r; x.ck = c; x.en = e; x.cl = l; x.din = d; x.tag = tag;
        sbq.push_back(x);
    endtask

    // Driver: offers one write, pushes the expected trace, applies side stimulus.
    task automatic do_write(input logic [7:0] c, input logic [7:0] d, input int div,
                            input bit poke, input bit chg, input string tag);
        int n;
        n = (div == 0) ? 1 : div;
        @(negedge clk);
        step_div = div[7:0];
        wr_code  = c;
        wr_data  = d;
        wr_valid = 1'b1;
        #1;
        chk(wr_ready === 1'b1, "R2", "wr_ready before accept", {31'd0, wr_ready}, 32'd1);
        @(posedge clk);
        for (int j = 0; j <= 6 * n; j++) begin
            int p;
            p = j / n;
            if (j == 6 * n)
                push(1'b1, 1'b1, 1'b0, 1'b0, d, "R5");
            else
                push(1'b0, !(p >= 2 && p <= 4), (p == 1 || p == 2), 1'b0,
                     (p < 4) ? c : d, (p == 2 || p == 5) ? "R4" : tag);
        end
        for (int j = 0; j <= 6 * n; j++) begin
            @(negedge clk);
            if (poke && j < 2) begin
                wr_valid  = 1'b1;
                clr_valid = 1'b1;
                wr_code   = ~c;
            end else begin
                wr_valid  = 1'b0;
                clr_valid = 1'b0;
            end
            if (chg && j == 0) step_div = div[7:0] + 8'd5;
            if (chg && j == 3) step_div = div[7:0];
        end
        last_din = d;
    endtask

    task automatic do_clear(input int hold, input bit with_wr, input string tag);
        int h;
        h = (hold == 0) ? 1 : hold;
        @(negedge clk);
        clr_hold  = hold[15:0];
        clr_valid = 1'b1;
        if (with_wr) begin
            wr_valid = 1'b1;
            wr_code  = 8'h77;
            wr_data  = 8'h88;
        end
        #1;
        if (with_wr) begin
            chk(wr_ready === 1'b0, "R7", "wr_ready with clear pending", {31'd0, wr_ready}, 32'd0);
            chk(clr_ready === 1'b1, "R7", "clr_ready with clear pending", {31'd0, clr_ready}, 32'd1);
        end
        @(posedge clk);
        for (int j = 0; j <= 2 * h; j++)
            push((j == 2 * h), 1'b1, 1'b0, (j < h), last_din, (j == 2 * h) ? "R5" : tag);
        for (int j = 0; j <= 2 * h; j++) begin
            @(negedge clk);
            clr_valid = 1'b0;
            wr_valid  = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(tp_clk === 1'b1, "R1", "tp_clk", {31'd0, tp_clk}, 32'd1);
        chk(tp_en === 1'b0, "R1", "tp_en", {31'd0, tp_en}, 32'd0);
        chk(tp_clr === 1'b0, "R1", "tp_clr", {31'd0, tp_clr}, 32'd0);
        chk(tp_din === 8'h00, "R1", "tp_din", {24'd0, tp_din}, 32'd0);
        chk(wr_ready === 1'b1, "R1", "wr_ready", {31'd0, wr_ready}, 32'd1);
        chk(clr_ready === 1'b1, "R1", "clr_ready", {31'd0, clr_ready}, 32'd1);

        do_write(8'hA5, 8'h3C, 1, 1'b0, 1'b0, "R3");
        do_write(8'h44, 8'h1B, 3, 1'b0, 1'b0, "R2");
        do_write(8'h0F, 8'hF0, 0, 1'b0, 1'b0, "R9");
        do_write(8'h5A, 8'hC3, 2, 1'b1, 1'b0, "R8");
        do_write(8'h12, 8'h34, 2, 1'b0, 1'b1, "R10");
        do_clear(4, 1'b0, "R6");
        do_clear(0, 1'b0, "R9");
        do_clear(3, 1'b1, "R7");
        do_write(8'h80, 8'h01, 4, 1'b0, 1'b0, "R3");

        wait (sbq.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule